// File: doc/BRIEF.md
# Multi-Page Display Sequencer

This block decides which frame an LED matrix scanner puts on the display. It holds eight frame pages, numbered 0 to 7. The pages are grouped into four pairs: pages 0/1, 2/3, 4/5 and 6/7. Each page has a display period. Each pair has a repeat count and a combine mode.

Inside a pair, the first page is shown for its period and then the second page for its period. The pair is repeated as many extra times as its count asks. The sequencer then moves to the next pair, and after the last pair it returns to the first. While the second page of a pair is active, the frame shown can be that page alone, or a bitwise AND, OR or XOR of the two pages. Time is counted in scan ticks, which the scanner sends once per scan. A period unit is a fixed number of ticks, set by a parameter. The output frame is registered.

A page whose period is zero is passed over in a single clock cycle. A pair whose two periods are both zero is passed over as a whole. Dropping the enable sends the sequencer back to the start of page 0. Page 0 must be given a nonzero period.

Top module: `page_sequencer`

## Requirements
- R1: A page with period P>0 stays selected for exactly P*TICKS_PER_UNIT scan ticks, counted only while enable_i is high. With a tick every K cycles and no zero-period page, this is K*P*TICKS_PER_UNIT clock cycles.
- R2: The pairs are visited in the order 0/1, 2/3, 4/5, 6/7. After pair 6/7 the sequence returns to pair 0/1.
- R3: Within a pair, the even page is shown first and the odd page second.
- R4: With a repeat count N, the pair is shown N+1 times in a row before the next pair starts. A count of 0 shows the pair once.
- R5: While the odd page of pair j is active, the frame is chosen by the mode bits comb_mode_i[2j+:2]: 00 gives the odd page, 01 gives even AND odd, 10 gives even OR odd, 11 gives even XOR odd. The even page is always shown unchanged.
- R6: A page with period 0 is selected for one clock cycle. That cycle consumes no scan tick and leaves frame_o unchanged.
- R7: A pair whose two periods are both 0 takes one clock cycle in total, on its even page. The sequencer then moves on to the next pair, and frame_o is unchanged.
- R8: Page k sits at page_data_i[k*PAGE_W+:PAGE_W] and its period at period_i[k*8+:8]. The repeat count of pair j is loop_cnt_i[j*8+:8]. cur_page_o gives the index k of the selected page, that is the pair number followed by one bit that is 1 on the odd page.
- R9: While enable_i is low, the sequencer sits at the start of page 0 with its counters cleared. frame_o shows page 0 one cycle later. After enable_i rises, page 0 runs a full period.
- R10: frame_o is a register that follows the page selected in the previous cycle. In reset, frame_o is 0 and cur_page_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run the sequencer; when low, it returns to page 0 |
| scan_tick_i | input | 1 | One pulse per display scan |
| page_data_i | input | NUM_PAIRS*2*PAGE_W | All page frames, page k at bits k*PAGE_W |
| period_i | input | NUM_PAIRS*2*PRD_W | Period of each page, in units |
| loop_cnt_i | input | NUM_PAIRS*LOOP_W | Extra repeats of each pair |
| comb_mode_i | input | NUM_PAIRS*2 | Combine mode used during the odd page of each pair |
| cur_page_o | output | PAIR_W+1 | Index of the selected page |
| frame_o | output | PAGE_W | Frame on display |

## Verification
The bench uses the default four pairs of 64-bit pages and sets TICKS_PER_UNIT to 2. This keeps each page to a few cycles, so a single test can run through many full rotations and repeats. It still exercises a sub-unit counter that must carry into the unit count. The tick spacing can be changed during the run. This lets the same expected run lengths show that only ticks are counted and that a skipped page consumes no tick.

// File: rtl/pgseq_pkg.sv
package pgseq_pkg;
  typedef enum logic [1:0] {
    CMB_PASS = 2'b00,
    CMB_AND  = 2'b01,
    CMB_OR   = 2'b10,
    CMB_XOR  = 2'b11
  } cmb_mode_e;

  localparam int unsigned PAGES_PER_PAIR = 2;
endpackage

// File: rtl/pgseq_timer.sv
module pgseq_timer #(
  parameter int unsigned TPU   = 16,
  parameter int unsigned PRD_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic [PRD_W-1:0] period_i,
  output logic             done_o
);
  localparam int unsigned SUB_W = (TPU > 1) ? $clog2(TPU) : 1;

  logic [SUB_W-1:0] sub_q;
  logic [PRD_W-1:0] unit_q;
  logic             sub_last, unit_last, live;

  assign sub_last  = (sub_q == SUB_W'(TPU - 1));
  assign unit_last = (unit_q == period_i - 1'b1);
  assign live      = (period_i != '0);
  assign done_o    = en_i & tick_i & live & sub_last & unit_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q  <= '0;
      unit_q <= '0;
    end else if (restart_i || !en_i) begin
      sub_q  <= '0;
      unit_q <= '0;
    end else if (tick_i && live) begin
      if (sub_last) begin
        sub_q  <= '0;
        unit_q <= unit_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pgseq_ctrl.sv
module pgseq_ctrl #(
  parameter int unsigned NUM_PAIRS = 4,
  parameter int unsigned PRD_W     = 8,
  parameter int unsigned LOOP_W    = 8,
  localparam int unsigned PAIR_W   = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              done_i,
  input  logic [PRD_W-1:0]  prd_first_i,
  input  logic [PRD_W-1:0]  prd_second_i,
  input  logic [LOOP_W-1:0] loop_n_i,
  output logic [PAIR_W-1:0] pair_o,
  output logic              second_o,
  output logic              step_o
);
  logic [PAIR_W-1:0] pair_q, pair_inc;
  logic              second_q;
  logic [LOOP_W-1:0] loop_q;
  logic              empty_pair, cur_zero, adv;

  assign pair_inc   = (pair_q == PAIR_W'(NUM_PAIRS - 1)) ? '0 : pair_q + 1'b1;
  assign empty_pair = (prd_first_i == '0) && (prd_second_i == '0);
  assign cur_zero   = second_q ? (prd_second_i == '0) : (prd_first_i == '0);
  assign adv        = done_i | cur_zero;
  assign step_o     = !en_i | adv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pair_q   <= '0;
      second_q <= 1'b0;
      loop_q   <= '0;
    end else if (!en_i) begin
      pair_q   <= '0;
      second_q <= 1'b0;
      loop_q   <= '0;
    end else if (!second_q) begin
      if (empty_pair) begin
        pair_q <= pair_inc;
        loop_q <= '0;
      end else if (adv) begin
        second_q <= 1'b1;
      end
    end else if (adv) begin
      second_q <= 1'b0;
      if (loop_q < loop_n_i) begin
        loop_q <= loop_q + 1'b1;
      end else begin
        loop_q <= '0;
        pair_q <= pair_inc;
      end
    end
  end

  assign pair_o   = pair_q;
  assign second_o = second_q;

  assert_pair_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && pair_q != $past(pair_q)) |->
      (pair_q == (($past(pair_q) == PAIR_W'(NUM_PAIRS - 1)) ? '0 : PAIR_W'($past(pair_q) + 1'b1))));

  assert_loop_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_q <= loop_n_i);

  assert_disable_home_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (pair_q == '0 && !second_q && loop_q == '0));
endmodule

// File: rtl/pgseq_mux.sv
module pgseq_mux
  import pgseq_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = 4,
  parameter int unsigned PAGE_W    = 64,
  localparam int unsigned PAIR_W   = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
  input  logic [NUM_PAIRS*PAGES_PER_PAIR*PAGE_W-1:0] pages_i,
  input  logic [NUM_PAIRS*2-1:0]                     modes_i,
  input  logic [PAIR_W-1:0]                          pair_i,
  input  logic                                       second_i,
  output logic [PAGE_W-1:0]                          frame_o
);
  logic [PAGE_W-1:0] pg_a [NUM_PAIRS];
  logic [PAGE_W-1:0] pg_b [NUM_PAIRS];
  cmb_mode_e         mode [NUM_PAIRS];

  for (genvar j = 0; j < NUM_PAIRS; j++) begin : g_pair
    assign pg_a[j] = pages_i[(2*j)*PAGE_W +: PAGE_W];
    assign pg_b[j] = pages_i[(2*j+1)*PAGE_W +: PAGE_W];
    assign mode[j] = cmb_mode_e'(modes_i[2*j +: 2]);
  end

  logic [PAGE_W-1:0] a_sel, b_sel;
  cmb_mode_e         m_sel;

  assign a_sel = pg_a[pair_i];
  assign b_sel = pg_b[pair_i];
  assign m_sel = mode[pair_i];

  always_comb begin
    if (!second_i) begin
      frame_o = a_sel;
    end else begin
      unique case (m_sel)
        CMB_AND: frame_o = a_sel & b_sel;
        CMB_OR:  frame_o = a_sel | b_sel;
        CMB_XOR: frame_o = a_sel ^ b_sel;
        default: frame_o = b_sel;
      endcase
    end
  end
endmodule

// File: rtl/page_sequencer.sv
module page_sequencer
  import pgseq_pkg::*;
#(
  parameter int unsigned NUM_PAIRS      = 4,
  parameter int unsigned PAGE_W         = 64,
  parameter int unsigned PRD_W          = 8,
  parameter int unsigned LOOP_W         = 8,
  parameter int unsigned TICKS_PER_UNIT = 16,
  localparam int unsigned NUM_PAGES     = NUM_PAIRS * PAGES_PER_PAIR,
  localparam int unsigned PAIR_W        = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          enable_i,
  input  logic                          scan_tick_i,
  input  logic [NUM_PAGES*PAGE_W-1:0]   page_data_i,
  input  logic [NUM_PAGES*PRD_W-1:0]    period_i,
  input  logic [NUM_PAIRS*LOOP_W-1:0]   loop_cnt_i,
  input  logic [NUM_PAIRS*2-1:0]        comb_mode_i,
  output logic [PAIR_W:0]               cur_page_o,
  output logic [PAGE_W-1:0]             frame_o
);
  logic [PRD_W-1:0]  prd_arr  [NUM_PAGES];
  logic [LOOP_W-1:0] loop_arr [NUM_PAIRS];

  for (genvar k = 0; k < NUM_PAGES; k++) begin : g_prd
    assign prd_arr[k] = period_i[k*PRD_W +: PRD_W];
  end
  for (genvar j = 0; j < NUM_PAIRS; j++) begin : g_loop
    assign loop_arr[j] = loop_cnt_i[j*LOOP_W +: LOOP_W];
  end

  logic [PAIR_W-1:0] pair;
  logic              second, step, done;
  logic [PAIR_W:0]   page_idx;
  logic [PRD_W-1:0]  cur_prd;
  logic [PAGE_W-1:0] mux_frame, frame_q;

  assign page_idx = {pair, second};
  assign cur_prd  = prd_arr[page_idx];

  pgseq_timer #(.TPU(TICKS_PER_UNIT), .PRD_W(PRD_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (enable_i),
    .tick_i    (scan_tick_i),
    .restart_i (step),
    .period_i  (cur_prd),
    .done_o    (done)
  );

  pgseq_ctrl #(.NUM_PAIRS(NUM_PAIRS), .PRD_W(PRD_W), .LOOP_W(LOOP_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (enable_i),
    .done_i       (done),
    .prd_first_i  (prd_arr[{pair, 1'b0}]),
    .prd_second_i (prd_arr[{pair, 1'b1}]),
    .loop_n_i     (loop_arr[pair]),
    .pair_o       (pair),
    .second_o     (second),
    .step_o       (step)
  );

  pgseq_mux #(.NUM_PAIRS(NUM_PAIRS), .PAGE_W(PAGE_W)) u_mux (
    .pages_i  (page_data_i),
    .modes_i  (comb_mode_i),
    .pair_i   (pair),
    .second_i (second),
    .frame_o  (mux_frame)
  );

  // hold last frame across skipped pages
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              frame_q <= '0;
    else if (cur_prd != '0)   frame_q <= mux_frame;
  end

  assign frame_o    = frame_q;
  assign cur_page_o = page_idx;

  assert_tick_gated_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(enable_i) && $past(cur_prd) != '0 && !$past(scan_tick_i)) |->
      (page_idx == $past(page_idx)));

  assert_skip_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_prd == '0) |=> $stable(frame_q));
endmodule

// File: tb/page_sequencer_test.sv
`timescale 1ns/1ps
module page_sequencer_test;
  localparam int NP = 4;
  localparam int NG = 8;
  localparam int PW = 64;
  localparam int T  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic scan_tick = 1'b0;
  logic [NG*PW-1:0] page_data;
  logic [NG*8-1:0]  period;
  logic [NP*8-1:0]  loop_cnt;
  logic [NP*2-1:0]  comb_mode;
  logic [2:0]       cur_page;
  logic [PW-1:0]    frame;

  page_sequencer #(.NUM_PAIRS(NP), .PAGE_W(PW), .TICKS_PER_UNIT(T)) uut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .scan_tick_i(scan_tick),
    .page_data_i(page_data), .period_i(period), .loop_cnt_i(loop_cnt),
    .comb_mode_i(comb_mode), .cur_page_o(cur_page), .frame_o(frame)
  );

  always #2.5 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  int tick_gap = 1;
  int tcnt = 0;

  int          prd [NG];
  int          lp  [NP];
  int          md  [NP];
  logic [PW-1:0] pg [NG];
  int exp_pg [$];
  int exp_len[$];

  always @(negedge clk) begin
    if (tcnt >= tick_gap - 1) tcnt = 0; else tcnt = tcnt + 1;
    scan_tick = (tcnt == 0);
  end

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung, expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  task automatic check(bit ok, string req, string msg);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic apply_cfg();
    for (int k = 0; k < NG; k++) begin
      page_data[k*PW +: PW] = pg[k];
      period[k*8 +: 8] = 8'(prd[k]);
    end
    for (int j = 0; j < NP; j++) begin
      loop_cnt[j*8 +: 8] = 8'(lp[j]);
      comb_mode[j*2 +: 2] = 2'(md[j]);
    end
  endtask

  task automatic default_cfg();
    for (int k = 0; k < NG; k++) begin
      prd[k] = 1;
      pg[k] = {$urandom(), $urandom()} ^ (64'h1111_0000_0000_0001 << k);
    end
    for (int j = 0; j < NP; j++) begin
      lp[j] = 0;
      md[j] = 0;
    end
  endtask

  function automatic logic [PW-1:0] compose(int k);
    if (k % 2 == 0) return pg[k];
    case (md[k/2])
      1: return pg[k-1] & pg[k];
      2: return pg[k-1] | pg[k];
      3: return pg[k-1] ^ pg[k];
      default: return pg[k];
    endcase
  endfunction

  task automatic build_model(int n);
    int p = 0;
    exp_pg.delete();
    exp_len.delete();
    while (exp_pg.size() < n) begin
      int a = 2*p;
      int b = 2*p + 1;
      if (prd[a] == 0 && prd[b] == 0) begin
        exp_pg.push_back(a); exp_len.push_back(1);
      end else begin
        for (int r = 0; r <= lp[p]; r++) begin
          exp_pg.push_back(a); exp_len.push_back(prd[a] != 0 ? prd[a]*T*tick_gap : 1);
          exp_pg.push_back(b); exp_len.push_back(prd[b] != 0 ? prd[b]*T*tick_gap : 1);
        end
      end
      p = (p + 1) % NP;
    end
  endtask

  // enable, record page run lengths and compare to model; frame checked each cycle
  task automatic run_check(string req, string freq, int nruns);
    int idx = 0;
    int len = 0;
    int prev = -1;
    int guard = 0;
    logic [PW-1:0] efr;
    apply_cfg();
    build_model(nruns + 1);
    repeat (3) @(negedge clk);
    efr = compose(0);
    enable = 1'b1;
    while (idx <= nruns && guard < 20000) begin
      int p;
      @(negedge clk);
      guard++;
      p = int'(cur_page);
      check(frame == efr, freq, $sformatf("frame %h, expected %h (page %0d)", frame, efr, p));
      if (prd[p] != 0) efr = compose(p);
      if (prev < 0) begin
        prev = p; len = 1;
      end else if (p == prev) begin
        len++;
      end else begin
        if (idx > 0)
          check(prev == exp_pg[idx] && len == exp_len[idx], req,
                $sformatf("run %0d page %0d len %0d, expected page %0d len %0d",
                          idx, prev, len, exp_pg[idx], exp_len[idx]));
        idx++;
        prev = p; len = 1;
      end
    end
    check(idx > nruns, req, $sformatf("runs seen %0d, expected %0d", idx, nruns + 1));
    enable = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    default_cfg();
    apply_cfg();
    #1;
    check(frame == '0, "R10", $sformatf("reset frame %h, expected 0", frame));
    check(cur_page == 3'd0, "R10", $sformatf("reset page %0d, expected 0", cur_page));
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(frame == pg[0], "R9", $sformatf("idle frame %h, expected %h", frame, pg[0]));
    check(cur_page == 3'd0, "R9", $sformatf("idle page %0d, expected 0", cur_page));
  endtask

  task automatic t_basic();
    default_cfg();
    tick_gap = 1;
    run_check("R2", "R8", 17);
  endtask

  task automatic t_order_pairs();
    default_cfg();
    prd[0] = 2; prd[1] = 3; prd[4] = 4;
    tick_gap = 1;
    run_check("R3", "R10", 12);
  endtask

  task automatic t_loop();
    default_cfg();
    prd[1] = 2; lp[0] = 2; lp[2] = 1; prd[4] = 2; lp[3] = 3;
    tick_gap = 1;
    run_check("R4", "R10", 24);
  endtask

  task automatic t_combine();
    default_cfg();
    md[0] = 0; md[1] = 1; md[2] = 2; md[3] = 3;
    lp[1] = 1;
    tick_gap = 1;
    run_check("R5", "R5", 12);
  endtask

  task automatic t_zero_page();
    default_cfg();
    prd[1] = 0; prd[4] = 0; prd[7] = 0; lp[0] = 1;
    md[0] = 3; md[2] = 1;
    tick_gap = 1;
    run_check("R6", "R6", 16);
  endtask

  task automatic t_zero_pair();
    default_cfg();
    prd[2] = 0; prd[3] = 0; prd[6] = 0; prd[7] = 0; lp[1] = 2;
    tick_gap = 1;
    run_check("R7", "R7", 10);
  endtask

  task automatic t_sparse();
    default_cfg();
    prd[0] = 2; prd[3] = 3; lp[2] = 1;
    tick_gap = 3;
    run_check("R1", "R1", 12);
    tick_gap = 1;
  endtask

  task automatic t_disable();
    int cnt = 0;
    int guard = 0;
    default_cfg();
    prd[0] = 3;
    tick_gap = 1;
    apply_cfg();
    repeat (3) @(negedge clk);
    enable = 1'b1;
    while (cur_page != 3'd3 && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    enable = 1'b0;
    @(negedge clk);
    check(cur_page == 3'd0, "R9", $sformatf("page after disable %0d, expected 0", cur_page));
    @(negedge clk);
    check(frame == pg[0], "R9", $sformatf("frame after disable %h, expected %h", frame, pg[0]));
    enable = 1'b1;
    guard = 0;
    @(negedge clk);
    while (cur_page == 3'd0 && guard < 1000) begin
      cnt++;
      guard++;
      @(negedge clk);
    end
    check(cnt == 3*T - 1, "R9", $sformatf("page 0 cycles after enable %0d, expected %0d", cnt, 3*T - 1));
    check(cur_page == 3'd1, "R9", $sformatf("next page %0d, expected 1", cur_page));
    enable = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_order_pairs();
    t_loop();
    t_combine();
    t_zero_page();
    t_zero_pair();
    t_sparse();
    t_disable();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule